// File: doc/BRIEF.md
# First-Order Delta-Sigma Bitstream Modulator

This block turns a slowly varying signed fixed-point level into a one-bit pulse stream. The bitstream's running mean tracks the input. Each advance of the state is gated by a clock-enable strobe, and that strobe sets the pulse rate. The datapath is entirely digital and has four parts:

- a difference stage, which subtracts the previous output level from the input;
- an accumulator, which integrates that difference;
- a strict sign quantizer;
- a registered output bit, which also serves as the one-step-delayed feedback.

The input word is a 16-bit two's-complement fraction. It spans -1 (0x8000) to just under +1 (0x7FFF). Internally the two output levels are worth +32768 and -32768, in an accumulator at least four bits wider than the input. A downstream averaging filter and decimator recover a multi-bit sample from the stream.

Top module: `dsm_modulator`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator clears to zero and `bit_out` becomes 1, which represents a +1 level.
- R2: On a rising edge where `rst` is low and `step_en` is low, neither `bit_out` nor the accumulator changes, whatever `din` does.
- R3: On each enabled step, the accumulator adds the sign-extended `din` and subtracts the level encoded by the current `bit_out`.
- R4: On each enabled step, `bit_out` takes the quantized new accumulator value. The result is 1 only when that value is strictly greater than zero, and an accumulator of exactly zero yields 0.
- R5: `bit_out` = 1 encodes the +1 level, which is worth +32768 in the feedback. `bit_out` = 0 encodes the -1 level, which is worth -32768.
- R6: For a constant input v (read as din/32768), the count of ones over the 1024 pulses after reset is within 4 of 1024·(v+1)/2.
- R7: For any sequence of input words, the accumulator stays within -65536 to +65536 and never wraps.
- R8: When `rst` and `step_en` are high at the same edge, the reset result of R1 is taken and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance strobe; one modulator step per high cycle |
| din | input | 16 | Signed Q1.15 input level |
| bit_out | output | 1 | Registered pulse bit (1 = +1, 0 = -1) |

## Verification
Two pairs of functions can fall in the same cycle, and each pair is provoked directly.

The first pair is reset and step: a step strobe with a full-scale input is raised in the very cycle that reset is asserted. Correct priority is judged by the output being 1. The judgement then continues with the following zero-input steps, which must give the sequence expected from an accumulator of exactly zero.

The second pair is the quantizer's zero boundary and the accumulator update. A zero input after reset drives the accumulator onto exactly zero on the second step, and the output bit must read 0 there.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

   // Output level carried on the pulse bit and fed back to the difference stage.
   typedef enum logic {
      LVL_NEG = 1'b0,
      LVL_POS = 1'b1
   } level_e;

   // Smallest accumulator headroom, in bits above the input width.
   localparam int DSM_MIN_GUARD = 4;

   // Accumulator width for a given input width and headroom.
   function automatic int acc_width(input int in_w, input int guard_w);
      return in_w + guard_w;
   endfunction

endpackage

// File: rtl/dsm_diff.sv
module dsm_diff #(
   parameter int IN_W  = 16,
   parameter int ACC_W = 20
) (
   input  logic [IN_W-1:0]          din,
   input  dsm_pkg::level_e          fb_lvl,
   output logic signed [ACC_W-1:0]  delta
);
   import dsm_pkg::*;

   // Magnitude of one output level: 2^(IN_W-1) in the widened datapath.
   localparam logic signed [ACC_W-1:0] FULL_SCALE = ACC_W'(1) << (IN_W - 1);

   logic signed [ACC_W-1:0] din_ext;

   assign din_ext = ACC_W'($signed(din));

   always_comb begin
      if (fb_lvl == LVL_POS) begin
         delta = din_ext - FULL_SCALE;
      end else begin
         delta = din_ext + FULL_SCALE;
      end
   end

endmodule

// File: rtl/dsm_accum.sv
module dsm_accum #(
   parameter int ACC_W = 20
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [ACC_W-1:0]  delta,
   output logic signed [ACC_W-1:0]  integ_d,
   output logic signed [ACC_W-1:0]  integ_q
);

   assign integ_d = integ_q + delta;

   always_ff @(posedge clk) begin
      if (rst) begin
         integ_q <= '0;
      end else if (en) begin
         integ_q <= integ_d;
      end
   end

endmodule

// File: rtl/dsm_quant.sv
module dsm_quant #(
   parameter int ACC_W = 20
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [ACC_W-1:0]  integ_d,
   output dsm_pkg::level_e          lvl_q
);
   import dsm_pkg::*;

   logic above_zero;

   // Strict test: non-negative sign and not all zero.
   assign above_zero = !integ_d[ACC_W-1] && (integ_d != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q <= LVL_POS;
      end else if (en) begin
         lvl_q <= above_zero ? LVL_POS : LVL_NEG;
      end
   end

endmodule

// File: rtl/dsm_modulator.sv
module dsm_modulator #(
   parameter int IN_W    = 16,
   parameter int GUARD_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_en,
   input  logic [IN_W-1:0]  din,
   output logic             bit_out
);
   import dsm_pkg::*;

   localparam int ACC_W = acc_width(IN_W, GUARD_W);

   generate
      if (IN_W < 2) begin : g_bad_in_w
         $error("dsm_modulator: IN_W must be at least 2");
      end
      if (GUARD_W < DSM_MIN_GUARD) begin : g_bad_guard
         $error("dsm_modulator: GUARD_W below the minimum headroom");
      end
   endgenerate

   level_e                   lvl_q;
   logic signed [ACC_W-1:0]  delta;
   logic signed [ACC_W-1:0]  integ_d;
   logic signed [ACC_W-1:0]  integ_q;

   dsm_diff #(
      .IN_W  (IN_W),
      .ACC_W (ACC_W)
   ) i_diff (
      .din    (din),
      .fb_lvl (lvl_q),
      .delta  (delta)
   );

   dsm_accum #(
      .ACC_W (ACC_W)
   ) i_accum (
      .clk     (clk),
      .rst     (rst),
      .en      (step_en),
      .delta   (delta),
      .integ_d (integ_d),
      .integ_q (integ_q)
   );

   dsm_quant #(
      .ACC_W (ACC_W)
   ) i_quant (
      .clk     (clk),
      .rst     (rst),
      .en      (step_en),
      .integ_d (integ_d),
      .lvl_q   (lvl_q)
   );

   assign bit_out = (lvl_q == LVL_POS);

endmodule

// File: rtl/dsm_modulator_chk.sv
module dsm_modulator_chk #(
   parameter int IN_W  = 16,
   parameter int ACC_W = 20
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     step_en,
   input logic [IN_W-1:0]          din,
   input logic                     bit_out,
   input logic signed [ACC_W-1:0]  integ
);

   localparam logic signed [ACC_W-1:0] FS    = ACC_W'(1) << (IN_W - 1);
   localparam logic signed [ACC_W-1:0] LIM_P = FS + FS;
   localparam logic signed [ACC_W-1:0] LIM_N = -(FS + FS);

   logic signed [ACC_W-1:0] din_x;
   logic signed [ACC_W-1:0] lvl_x;
   logic signed [ACC_W-1:0] integ_exp;

   assign din_x     = ACC_W'($signed(din));
   assign lvl_x     = bit_out ? FS : -FS;
   assign integ_exp = integ + din_x - lvl_x;

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (bit_out && (integ == '0)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> ($stable(bit_out) && $stable(integ)));

   assert_update_R3: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (integ == $past(integ_exp)));

   assert_quant_R4: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (bit_out == (!integ[ACC_W-1] && (integ != '0))));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
      (integ >= LIM_N) && (integ <= LIM_P));

endmodule

bind dsm_modulator dsm_modulator_chk #(
   .IN_W  (IN_W),
   .ACC_W (ACC_W)
) i_chk (
   .clk     (clk),
   .rst     (rst),
   .step_en (step_en),
   .din     (din),
   .bit_out (bit_out),
   .integ   (integ_q)
);

// File: tb/test_dsm_modulator.sv
module test_dsm_modulator;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        step_en = 1'b0;
   logic [15:0] din = '0;
   logic        bit_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Reference model state
   int   m_integ;
   logic m_bit;

   always #4 clk = ~clk;

   dsm_modulator i_dsm_modulator (
      .clk     (clk),
      .rst     (rst),
      .step_en (step_en),
      .din     (din),
      .bit_out (bit_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_integ = 0;
      m_bit   = 1'b1;
   endtask

   // R3/R4/R5: integrate input minus level, strict sign decision
   task automatic model_step(input logic [15:0] v);
      int lvl;
      lvl     = m_bit ? 32768 : -32768;
      m_integ = m_integ + int'($signed(v)) - lvl;
      m_bit   = (m_integ > 0);
   endtask

   // All tasks start and end at a falling edge
   task automatic do_reset();
      rst = 1'b1;
      step_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      check("R1 reset level", int'(bit_out), 1);
   endtask

   task automatic do_step(input logic [15:0] v, input string req);
      step_en = 1'b1;
      din = v;
      @(negedge clk);
      step_en = 1'b0;
      model_step(v);
      check(req, int'(bit_out), int'(m_bit));
   endtask

   task automatic t_zero_boundary();
      do_reset();
      do_step(16'h0000, "R3 zero step 1");
      check("R5 first step level", int'(bit_out), 0);
      do_step(16'h0000, "R4 zero step 2");
      check("R4 exact zero gives 0", int'(bit_out), 0);
      do_step(16'h0000, "R4 zero step 3");
      check("R4 positive gives 1", int'(bit_out), 1);
   endtask

   task automatic t_levels();
      do_reset();
      do_step(16'h0001, "R5 small input");
      check("R5 after +1 feedback", int'(bit_out), 0);
      do_step(16'h7FFF, "R5 max after -1 feedback");
      check("R5 level value 32768", int'(bit_out), 1);
   endtask

   task automatic t_density(input logic [15:0] v);
      int  ones;
      real expv;
      int  diff;
      do_reset();
      ones = 0;
      for (int i = 0; i < 1024; i++) begin
         do_step(v, "R3 model match");
         if (bit_out) ones++;
      end
      expv = 1024.0 * ((real'($signed(v)) / 32768.0) + 1.0) / 2.0;
      diff = int'(real'(ones) - expv);
      if (diff < 0) diff = -diff;
      checks++;
      if (diff > 4) begin
         errors++;
         $display("FAIL R6 density din=%h: got %0d expected %0d", v, ones, int'(expv));
      end
   endtask

   task automatic t_hold();
      logic held;
      do_reset();
      for (int i = 0; i < 5; i++) do_step(16'h2000, "R3 pre-hold");
      held = bit_out;
      for (int i = 0; i < 10; i++) begin
         din = 16'(i * 16'h1357);
         @(negedge clk);
         check("R2 held bit", int'(bit_out), int'(held));
      end
      for (int i = 0; i < 8; i++) do_step(16'hE000, "R2 state kept across hold");
   endtask

   task automatic t_reset_with_step();
      do_reset();
      for (int i = 0; i < 7; i++) do_step(16'h9000, "R3 pre-reset");
      rst = 1'b1;
      step_en = 1'b1;
      din = 16'h7FFF;
      @(negedge clk);
      rst = 1'b0;
      step_en = 1'b0;
      model_reset();
      check("R8 reset wins over step", int'(bit_out), 1);
      do_step(16'h0000, "R8 integrator cleared");
      do_step(16'h0000, "R8 integrator cleared step 2");
      check("R8 zero sequence", int'(bit_out), 0);
   endtask

   task automatic t_extremes();
      do_reset();
      for (int i = 0; i < 300; i++) do_step(16'h8000, "R7 min input");
      for (int i = 0; i < 300; i++) do_step(16'h7FFF, "R7 max input");
      for (int i = 0; i < 300; i++) do_step((i % 2) ? 16'h8000 : 16'h7FFF, "R7 alternating extremes");
   endtask

   initial begin
      @(negedge clk);
      t_zero_boundary();
      t_levels();
      t_density(16'h0000);
      t_density(16'h4000);
      t_density(16'hC000);
      t_density(16'h7FFF);
      t_density(16'h8000);
      t_hold();
      t_reset_with_step();
      t_extremes();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule